// File: doc/BRIEF.md
# Doorbell Job Mailbox Controller

This block is the device side of a job mailbox that a host reaches through a small shared memory and a doorbell register. The memory has four regions, selected by byte address bits [17:16]: standard write (region 0, 0x00000), standard read (region 1, 0x10000), kernel write (region 2, 0x20000) and kernel read (region 3, 0x30000). In every region the word at byte offset 0 is a control word, the word at offset 4 is a byte length, and payload words start at offset 8. To send a job, the host fills a write region and rings a request bit. To fetch results, it puts a control word and the largest length it will take into a read region and rings the matching read request bit. The controller answers each request by setting exactly one outcome bit, either OK or FAILED, for that channel and direction.

Write payload leaves on a valid/ready output stream toward local consumer logic. Returned data comes from a local producer on a valid/ready input stream. A read with control word 1 (pull) stores the returned words in the read region so the host can fetch them from there. A read with control word 2 (push) forwards them on the output stream, flagged as push data, toward a host-bound mover. Both streams follow the usual rules. A beat moves only in a cycle where valid and ready are both high. A source that raises valid keeps valid, data and the last flag unchanged until that cycle. Ready may drop at any time. In push mode the input ready follows the output ready, so back-pressure passes straight through.

The payload capacity of a region is DATA_WORDS words. The write length limit is the smaller of 0xFFF8 and that capacity in bytes, which is 64 bytes with the default parameters.

Top module: `jobbox_ctrl`

## Requirements
- R1: After reset the doorbell reads 0, jo_valid is 0 and ji_ready is 0.
- R2: A host write to an address with word offset below DATA_WORDS+2 in any region is stored and appears on hst_rdata one cycle after hst_re. A read of any higher offset returns 0.
- R3: Host doorbell writes set request bits 16 to 20 where the data bit is 1 and clear outcome bits 0 to 7 where the data bit is 1. All other bits always read 0. The controller clears a request bit when it starts to serve that request.
- R4: A write request (bit 16 for standard, bit 19 for kernel) with control 1 and a byte length at or below the limit sends ceil(length/4) payload words in address order on the output stream. These beats have jo_push=0, jo_kern set to the channel, and jo_last on the final word. The controller then sets write-OK (bit 0 for standard, bit 4 for kernel).
- R5: A write request whose control is not 1, or whose length exceeds the limit, sends no words and sets write-FAILED (bit 1 for standard, bit 5 for kernel).
- R6: A read request (bit 17 for standard, bit 20 for kernel) with control 1 raises ji_ready with ji_kern set to the channel. It stores the returned words from offset 8, replaces the length word with 4 times the word count, and sets read-OK (bit 2 for standard, bit 6 for kernel).
- R7: A read request with control 2 forwards every returned word on the output stream with jo_push=1. It then updates the length word and sets read-OK.
- R8: If 4 times the returned word count exceeds the host's maximum length, or a pull read returns more than DATA_WORDS words, the controller sets read-FAILED (bit 3 for standard, bit 7 for kernel). The length word is left unchanged.
- R9: A read request with a control value other than 1 or 2 sets read-FAILED without ever raising ji_ready.
- R10: While jo_valid is high and jo_ready is low, the output beat stays unchanged.
- R11: The controller serves one request at a time. Among pending requests, bit 16 goes first, then 17, then 19, then 20. A request rung again while its channel is busy is served after the current job.
- R12: Debug bit 18 is stored and readable but starts no job.
- R13: A write request with control 1 and length 0 sends no words and sets write-OK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_we | input | 1 | Host shared-memory write strobe |
| hst_re | input | 1 | Host shared-memory read strobe |
| hst_addr | input | ADDR_W | Host byte address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, valid one cycle after hst_re |
| bell_we | input | 1 | Host doorbell write strobe |
| bell_wdata | input | 32 | Doorbell write data (set request bits, clear outcome bits) |
| bell_q | output | 32 | Doorbell register value |
| jo_valid | output | 1 | Output stream valid |
| jo_ready | input | 1 | Output stream ready |
| jo_data | output | 32 | Output stream word |
| jo_last | output | 1 | Final word of the job |
| jo_kern | output | 1 | Beat belongs to the kernel channel |
| jo_push | output | 1 | Beat is push-mode read data |
| ji_valid | input | 1 | Input stream valid |
| ji_ready | output | 1 | Input stream ready |
| ji_data | input | 32 | Input stream word |
| ji_last | input | 1 | Final returned word |
| ji_kern | output | 1 | Channel the producer is serving |

## Verification
The bench targets the length boundaries. A 64-byte write must pass and a 65-byte write must fail; a limit check that is off by one turns one of them into the wrong outcome bit and makes unexpected stream beats appear or expected ones go missing. Read overflow is tested both against the host's maximum length and against region capacity. A design that truncated the data or wrote the length anyway would show a changed length word. A bad read control must fail without a producer handshake, and a controller that always gathered would raise ji_ready and hang. A double ring and a simultaneous two-channel ring check that a re-rung bit is not lost and that service order follows the bit priority. A wrong order shows up as scoreboard data mismatches.

// File: rtl/jobbox_pkg.sv
package jobbox_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_SEND,
    ST_GATHER,
    ST_DONE
  } eng_state_t;

  // control word values
  localparam logic [31:0] CTRL_PULL = 32'd1;
  localparam logic [31:0] CTRL_PUSH = 32'd2;

  // request vector index = doorbell bit - 16
  localparam int RQ_WR_STD = 0;
  localparam int RQ_RD_STD = 1;
  localparam int RQ_WR_KRN = 3;
  localparam int RQ_RD_KRN = 4;
endpackage

// File: rtl/jobbox_ram.sv
module jobbox_ram #(
  parameter int DATA_WORDS = 16,
  parameter int ADDR_W     = 18,
  localparam int SLOT      = DATA_WORDS + 2,
  localparam int DEPTH     = 4 * SLOT,
  localparam int IDX_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_we,
  input  logic              h_re,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [31:0]       h_wdata,
  output logic [31:0]       h_rdata,
  input  logic              e_we,
  input  logic [IDX_W-1:0]  e_idx,
  input  logic [31:0]       e_wdata,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic [31:0]       ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [31:0]       rb_data
);
  localparam int OFF_W = ADDR_W - 4;

  logic [31:0]      mem [DEPTH];
  logic [1:0]       region;
  logic [OFF_W-1:0] off;
  logic             in_range;
  logic [IDX_W-1:0] h_idx;
  logic             unused_lsb;

  assign region     = h_addr[ADDR_W-1 -: 2];
  assign off        = h_addr[ADDR_W-3:2];
  assign unused_lsb = ^h_addr[1:0];
  assign in_range   = 32'(off) < SLOT;
  assign h_idx      = IDX_W'(32'(region) * SLOT + 32'(off));

  // engine port has priority over a colliding host write
  always_ff @(posedge clk) begin
    if (e_we)
      mem[e_idx] <= e_wdata;
    else if (h_we && in_range)
      mem[h_idx] <= h_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      h_rdata <= '0;
    else if (h_re)
      h_rdata <= in_range ? mem[h_idx] : 32'd0;
  end

  assign ra_data = mem[ra_idx];
  assign rb_data = mem[rb_idx];
endmodule

// File: rtl/jobbox_bell.sv
module jobbox_bell (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_we,
  input  logic [31:0] h_wdata,
  input  logic [4:0]  req_clr,
  input  logic [7:0]  done_set,
  output logic [31:0] q
);
  logic [4:0] req;
  logic [7:0] done;

  // a fresh ring beats a same-cycle clear; a fresh outcome beats a host clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req  <= '0;
      done <= '0;
    end else begin
      req  <= (req & ~req_clr) | (h_we ? h_wdata[20:16] : 5'd0);
      done <= (done & ~(h_we ? h_wdata[7:0] : 8'd0)) | done_set;
    end
  end

  assign q = {11'd0, req, 8'd0, done};
endmodule

// File: rtl/jobbox_engine.sv
module jobbox_engine
  import jobbox_pkg::*;
#(
  parameter int          DATA_WORDS = 16,
  parameter logic [31:0] MAX_LEN    = 32'h0000_FFF8,
  localparam int SLOT  = DATA_WORDS + 2,
  localparam int DEPTH = 4 * SLOT,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       req,
  output logic [4:0]       req_clr,
  output logic [7:0]       done_set,
  output logic [IDX_W-1:0] ra_idx,
  input  logic [31:0]      ra_data,
  output logic [IDX_W-1:0] rb_idx,
  input  logic [31:0]      rb_data,
  output logic             e_we,
  output logic [IDX_W-1:0] e_idx,
  output logic [31:0]      e_wdata,
  output logic             jo_valid,
  input  logic             jo_ready,
  output logic [31:0]      jo_data,
  output logic             jo_last,
  output logic             jo_kern,
  output logic             jo_push,
  input  logic             ji_valid,
  output logic             ji_ready,
  input  logic [31:0]      ji_data,
  input  logic             ji_last,
  output logic             ji_kern
);
  localparam logic [31:0] CAP_BYTES = 32'(DATA_WORDS * 4);
  localparam logic [31:0] LEN_LIMIT = (CAP_BYTES < MAX_LEN) ? CAP_BYTES : MAX_LEN;

  eng_state_t       st;
  logic             kern, rd, push, ok, ovf;
  logic [15:0]      nwords, idx, cnt, cnt_n, len_words;
  logic [IDX_W-1:0] base;
  logic             wr_ok, over, in_hs, out_hs, last_word;

  assign base      = IDX_W'(32'({kern, rd}) * SLOT);
  assign ra_idx    = (st == ST_SEND) ? base + IDX_W'(2) + IDX_W'(idx) : base;
  assign rb_idx    = base + IDX_W'(1);
  assign wr_ok     = (ra_data == CTRL_PULL) && (rb_data <= LEN_LIMIT);
  assign len_words = 16'((rb_data + 32'd3) >> 2);
  assign cnt_n     = cnt + 16'd1;
  assign over      = ((32'(cnt_n) << 2) > rb_data) ||
                     (!push && cnt >= 16'(DATA_WORDS));
  assign last_word = idx == nwords - 16'd1;

  // streams
  assign jo_valid = (st == ST_SEND) || (st == ST_GATHER && push && ji_valid);
  assign jo_data  = (st == ST_SEND) ? ra_data : ji_data;
  assign jo_last  = (st == ST_SEND) ? last_word : ji_last;
  assign jo_kern  = kern;
  assign jo_push  = (st == ST_GATHER) && push;
  assign ji_ready = (st == ST_GATHER) && (push ? jo_ready : 1'b1);
  assign ji_kern  = kern;
  assign in_hs    = ji_valid && ji_ready;
  assign out_hs   = jo_valid && jo_ready;

  always_comb begin
    req_clr  = '0;
    done_set = '0;
    e_we     = 1'b0;
    e_idx    = '0;
    e_wdata  = '0;
    if (st == ST_IDLE) begin
      if      (req[RQ_WR_STD]) req_clr[RQ_WR_STD] = 1'b1;
      else if (req[RQ_RD_STD]) req_clr[RQ_RD_STD] = 1'b1;
      else if (req[RQ_WR_KRN]) req_clr[RQ_WR_KRN] = 1'b1;
      else if (req[RQ_RD_KRN]) req_clr[RQ_RD_KRN] = 1'b1;
    end
    if (st == ST_GATHER && in_hs && !push && !(ovf || over)) begin
      e_we    = 1'b1;
      e_idx   = base + IDX_W'(2) + IDX_W'(cnt);
      e_wdata = ji_data;
    end
    if (st == ST_DONE) begin
      done_set[{kern, rd, !ok}] = 1'b1;
      if (rd && ok) begin
        e_we    = 1'b1;
        e_idx   = rb_idx;
        e_wdata = 32'(cnt) << 2;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      kern   <= 1'b0;
      rd     <= 1'b0;
      push   <= 1'b0;
      ok     <= 1'b0;
      ovf    <= 1'b0;
      nwords <= '0;
      idx    <= '0;
      cnt    <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (req[RQ_WR_STD] || req[RQ_RD_STD] || req[RQ_WR_KRN] || req[RQ_RD_KRN]) begin
            if      (req[RQ_WR_STD]) {kern, rd} <= 2'b00;
            else if (req[RQ_RD_STD]) {kern, rd} <= 2'b01;
            else if (req[RQ_WR_KRN]) {kern, rd} <= 2'b10;
            else                     {kern, rd} <= 2'b11;
            st <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (!rd) begin
            if (wr_ok) begin
              nwords <= len_words;
              idx    <= '0;
              ok     <= 1'b1;
              st     <= (len_words == 16'd0) ? ST_DONE : ST_SEND;
            end else begin
              ok <= 1'b0;
              st <= ST_DONE;
            end
          end else if (ra_data == CTRL_PULL || ra_data == CTRL_PUSH) begin
            push <= ra_data == CTRL_PUSH;
            cnt  <= '0;
            ovf  <= 1'b0;
            st   <= ST_GATHER;
          end else begin
            ok <= 1'b0;
            st <= ST_DONE;
          end
        end
        ST_SEND: begin
          if (out_hs) begin
            idx <= idx + 16'd1;
            if (last_word) st <= ST_DONE;
          end
        end
        ST_GATHER: begin
          if (in_hs) begin
            cnt <= cnt_n;
            ovf <= ovf | over;
            if (ji_last) begin
              ok <= !(ovf | over);
              st <= ST_DONE;
            end
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/jobbox_ctrl.sv
module jobbox_ctrl #(
  parameter int          DATA_WORDS = 16,
  parameter int          ADDR_W     = 18,
  parameter logic [31:0] MAX_LEN    = 32'h0000_FFF8,
  localparam int IDX_W = $clog2(4 * (DATA_WORDS + 2))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_we,
  input  logic              hst_re,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [31:0]       hst_wdata,
  output logic [31:0]       hst_rdata,
  input  logic              bell_we,
  input  logic [31:0]       bell_wdata,
  output logic [31:0]       bell_q,
  output logic              jo_valid,
  input  logic              jo_ready,
  output logic [31:0]       jo_data,
  output logic              jo_last,
  output logic              jo_kern,
  output logic              jo_push,
  input  logic              ji_valid,
  output logic              ji_ready,
  input  logic [31:0]       ji_data,
  input  logic              ji_last,
  output logic              ji_kern
);
  logic [4:0]       req_clr;
  logic [7:0]       done_set;
  logic             e_we;
  logic [IDX_W-1:0] e_idx, ra_idx, rb_idx;
  logic [31:0]      e_wdata, ra_data, rb_data;

  jobbox_ram #(.DATA_WORDS(DATA_WORDS), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .h_we(hst_we), .h_re(hst_re), .h_addr(hst_addr),
    .h_wdata(hst_wdata), .h_rdata(hst_rdata),
    .e_we(e_we), .e_idx(e_idx), .e_wdata(e_wdata),
    .ra_idx(ra_idx), .ra_data(ra_data),
    .rb_idx(rb_idx), .rb_data(rb_data)
  );

  jobbox_bell u_bell (
    .clk(clk), .rst_n(rst_n),
    .h_we(bell_we), .h_wdata(bell_wdata),
    .req_clr(req_clr), .done_set(done_set), .q(bell_q)
  );

  jobbox_engine #(.DATA_WORDS(DATA_WORDS), .MAX_LEN(MAX_LEN)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .req(bell_q[20:16]), .req_clr(req_clr), .done_set(done_set),
    .ra_idx(ra_idx), .ra_data(ra_data), .rb_idx(rb_idx), .rb_data(rb_data),
    .e_we(e_we), .e_idx(e_idx), .e_wdata(e_wdata),
    .jo_valid(jo_valid), .jo_ready(jo_ready), .jo_data(jo_data),
    .jo_last(jo_last), .jo_kern(jo_kern), .jo_push(jo_push),
    .ji_valid(ji_valid), .ji_ready(ji_ready), .ji_data(ji_data),
    .ji_last(ji_last), .ji_kern(ji_kern)
  );
endmodule

// File: rtl/jobbox_ctrl_chk.sv
module jobbox_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] bell_q,
  input logic        jo_valid,
  input logic        jo_ready,
  input logic [31:0] jo_data,
  input logic        jo_last,
  input logic        jo_push,
  input logic        ji_ready
);
  a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (jo_valid && !jo_ready) |=> (jo_valid && $stable(jo_data) &&
                                 $stable(jo_last) && $stable(jo_push)));

  a_r9_in_only_push_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (ji_ready && jo_valid) |-> jo_push);

  a_r4_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bell_q[7:0] & ~$past(bell_q[7:0])));

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bell_q[15:8] == 8'd0) && (bell_q[31:21] == 11'd0));

  a_r11_one_job_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    (jo_valid && !jo_push) |-> !ji_ready);
endmodule

bind jobbox_ctrl jobbox_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bell_q(bell_q),
  .jo_valid(jo_valid), .jo_ready(jo_ready), .jo_data(jo_data),
  .jo_last(jo_last), .jo_push(jo_push), .ji_ready(ji_ready)
);

// File: tb/sim_jobbox_ctrl.sv
`timescale 1ns/1ps
module sim_jobbox_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_we = 1'b0, hst_re = 1'b0;
  logic [17:0] hst_addr = '0;
  logic [31:0] hst_wdata = '0, hst_rdata;
  logic        bell_we = 1'b0;
  logic [31:0] bell_wdata = '0, bell_q;
  logic        jo_valid, jo_ready = 1'b1, jo_last, jo_kern, jo_push;
  logic [31:0] jo_data;
  logic        ji_valid = 1'b0, ji_ready, ji_last = 1'b0, ji_kern;
  logic [31:0] ji_data = '0;

  int total = 0, bad = 0, cyc = 0;
  logic [34:0] expq[$];
  logic        bp = 1'b0;
  logic [7:0]  lfsr = 8'h5A;
  logic        seen_ready = 1'b0, seen_out = 1'b0, kern_seen = 1'b0;

  always #4 clk = ~clk;

  jobbox_ctrl u0 (.*);

  task automatic chk(input bit c, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!c) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // back-pressure source, changes away from the sampling edge
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    jo_ready = bp ? lfsr[0] : 1'b1;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (ji_ready) begin seen_ready = 1'b1; kern_seen = ji_kern; end
    if (jo_valid) seen_out = 1'b1;
    if (rst_n && jo_valid && jo_ready) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R4/R5 unexpected beat", jo_data, 32'h0);
      end else begin
        logic [34:0] e;
        e = expq.pop_front();
        chk({jo_data, jo_last, jo_kern, jo_push} == e, "R4/R7/R10 beat",
            {jo_last, jo_kern, jo_push, jo_data[28:0]}, {e[2:0], e[31:3]});
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic hw(input logic [17:0] a, input logic [31:0] d);
    @(posedge clk); #2; hst_we = 1'b1; hst_addr = a; hst_wdata = d;
    @(posedge clk); #2; hst_we = 1'b0;
  endtask

  task automatic hr(input logic [17:0] a, output logic [31:0] d);
    @(posedge clk); #2; hst_re = 1'b1; hst_addr = a;
    @(posedge clk); #2; hst_re = 1'b0;
    @(negedge clk); d = hst_rdata;
  endtask

  task automatic ring(input logic [31:0] v);
    @(posedge clk); #2; bell_we = 1'b1; bell_wdata = v;
    @(posedge clk); #2; bell_we = 1'b0;
  endtask

  task automatic wait_done(input logic [7:0] mask, output logic [7:0] got);
    int n = 0;
    got = 8'h0;
    @(negedge clk);
    while ((bell_q[7:0] & mask) == 8'h0 && n < 3000) begin @(negedge clk); n++; end
    got = bell_q[7:0];
    if (n >= 3000) chk(1'b0, "timeout waiting outcome", 32'(got), 32'(mask));
    ring(32'(got));
  endtask

  task automatic exp_word(input logic [31:0] d, input bit l, input bit k, input bit p);
    expq.push_back({d, l, k, p});
  endtask

  task automatic produce(input int n, input logic [31:0] b);
    @(posedge clk); #2;
    for (int i = 0; i < n; i++) begin
      ji_valid = 1'b1; ji_data = b + 32'(i); ji_last = (i == n - 1);
      @(negedge clk);
      while (!ji_ready) @(negedge clk);
      @(posedge clk); #2;
    end
    ji_valid = 1'b0; ji_last = 1'b0;
  endtask

  task automatic write_job(input logic [17:0] rg, input logic [31:0] ctl, input logic [31:0] len,
                           input int nw, input logic [31:0] b);
    hw(rg, ctl);
    hw(rg + 18'd4, len);
    for (int i = 0; i < nw; i++) hw(rg + 18'd8 + 18'(4 * i), b + 32'(i));
  endtask

  initial begin
    logic [31:0] d;
    logic [7:0]  got;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk(bell_q == 32'h0, "R1 doorbell", bell_q, 32'h0);
    chk(!jo_valid && !ji_ready, "R1 streams idle", {jo_valid, ji_ready}, 0);

    // R2 host memory
    hw(18'h30008, 32'hDEAD_BEEF);
    hr(18'h30008, d);
    chk(d == 32'hDEAD_BEEF, "R2 readback", d, 32'hDEAD_BEEF);
    hr(18'h00100, d);
    chk(d == 32'h0, "R2 out of range", d, 0);

    // R3 / R12 doorbell masking and debug bit
    seen_out = 1'b0; seen_ready = 1'b0;
    ring(32'hFFE4_FF00);
    @(negedge clk);
    chk(bell_q == 32'h0004_0000, "R3 set mask", bell_q, 32'h0004_0000);
    repeat (20) @(negedge clk);
    chk(!seen_out && !seen_ready && bell_q == 32'h0004_0000, "R12 debug no job",
        bell_q, 32'h0004_0000);

    // R4 standard write, 10 bytes, back-pressure
    bp = 1'b1;
    write_job(18'h00000, 1, 10, 3, 32'hA000_0000);
    for (int i = 0; i < 3; i++) exp_word(32'hA000_0000 + 32'(i), i == 2, 1'b0, 1'b0);
    ring(32'h0001_0000);
    wait_done(8'hFF, got);
    chk(got == 8'h01, "R4 std write ok", 32'(got), 32'h01);
    chk(expq.size() == 0, "R4 all words", expq.size(), 0);
    @(negedge clk);
    chk(bell_q[16] == 1'b0 && bell_q[7:0] == 8'h0, "R3 clear bits", bell_q, 32'h0004_0000);

    // R4 kernel write at the 64-byte limit
    write_job(18'h20000, 1, 64, 16, 32'hB000_0000);
    for (int i = 0; i < 16; i++) exp_word(32'hB000_0000 + 32'(i), i == 15, 1'b1, 1'b0);
    ring(32'h0008_0000);
    wait_done(8'hFF, got);
    chk(got == 8'h10, "R4 kern write ok at limit", 32'(got), 32'h10);

    // R5 over limit and bad control
    write_job(18'h20000, 1, 65, 0, 0);
    ring(32'h0008_0000);
    wait_done(8'hFF, got);
    chk(got == 8'h20, "R5 kern over limit", 32'(got), 32'h20);
    write_job(18'h00000, 2, 8, 0, 0);
    ring(32'h0001_0000);
    wait_done(8'hFF, got);
    chk(got == 8'h02, "R5 bad control", 32'(got), 32'h02);

    // R13 zero length
    write_job(18'h00000, 1, 0, 0, 0);
    ring(32'h0001_0000);
    wait_done(8'hFF, got);
    chk(got == 8'h01, "R13 zero length ok", 32'(got), 32'h01);

    // R6 pull read
    hw(18'h10000, 1); hw(18'h10004, 16);
    kern_seen = 1'b1;
    ring(32'h0002_0000);
    fork produce(3, 32'hC000_0000); wait_done(8'hFF, got); join
    chk(got == 8'h04, "R6 pull ok", 32'(got), 32'h04);
    chk(kern_seen == 1'b0, "R6 ji_kern std", 32'(kern_seen), 0);
    hr(18'h10004, d);
    chk(d == 32'd12, "R6 length", d, 12);
    for (int i = 0; i < 3; i++) begin
      hr(18'h10008 + 18'(4 * i), d);
      chk(d == 32'hC000_0000 + 32'(i), "R6 stored data", d, 32'hC000_0000 + 32'(i));
    end

    // R7 push read on kernel channel
    hw(18'h30000, 2); hw(18'h30004, 100);
    for (int i = 0; i < 4; i++) exp_word(32'hE000_0000 + 32'(i), i == 3, 1'b1, 1'b1);
    ring(32'h0010_0000);
    fork produce(4, 32'hE000_0000); wait_done(8'hFF, got); join
    chk(got == 8'h40, "R7 push ok", 32'(got), 32'h40);
    chk(expq.size() == 0, "R7 all pushed", expq.size(), 0);
    hr(18'h30004, d);
    chk(d == 32'd16, "R7 length", d, 16);

    // R8 overflow against host maximum
    hw(18'h30000, 1); hw(18'h30004, 8);
    ring(32'h0010_0000);
    fork produce(3, 32'h1); wait_done(8'hFF, got); join
    chk(got == 8'h80, "R8 max overflow", 32'(got), 32'h80);
    chk(kern_seen == 1'b1, "R6 ji_kern kern", 32'(kern_seen), 1);
    hr(18'h30004, d);
    chk(d == 32'd8, "R8 length kept", d, 8);

    // R8 overflow against region capacity
    hw(18'h10000, 1); hw(18'h10004, 200);
    ring(32'h0002_0000);
    fork produce(17, 32'h2); wait_done(8'hFF, got); join
    chk(got == 8'h08, "R8 capacity overflow", 32'(got), 32'h08);
    hr(18'h10004, d);
    chk(d == 32'd200, "R8 length kept cap", d, 200);

    // R9 bad read control
    hw(18'h10000, 3);
    seen_ready = 1'b0;
    ring(32'h0002_0000);
    wait_done(8'hFF, got);
    chk(got == 8'h08, "R9 bad read ctl", 32'(got), 32'h08);
    chk(!seen_ready, "R9 no ready", 32'(seen_ready), 0);

    // R11 priority: std write before kern write
    write_job(18'h00000, 1, 4, 1, 32'h5151_0000);
    write_job(18'h20000, 1, 4, 1, 32'h7171_0000);
    exp_word(32'h5151_0000, 1'b1, 1'b0, 1'b0);
    exp_word(32'h7171_0000, 1'b1, 1'b1, 1'b0);
    ring(32'h0009_0000);
    wait_done(8'h30, got);
    chk(got == 8'h11, "R11 both served", 32'(got), 32'h11);
    chk(expq.size() == 0, "R11 order", expq.size(), 0);

    // R11 re-ring while busy
    write_job(18'h00000, 1, 64, 16, 32'h9000_0000);
    for (int j = 0; j < 2; j++)
      for (int i = 0; i < 16; i++) exp_word(32'h9000_0000 + 32'(i), i == 15, 1'b0, 1'b0);
    ring(32'h0001_0000);
    @(negedge clk);
    while (!jo_valid) @(negedge clk);
    ring(32'h0001_0000);
    for (int n = 0; n < 3000 && expq.size() != 0; n++) @(negedge clk);
    chk(expq.size() == 0, "R11 second job served", expq.size(), 0);
    repeat (5) @(negedge clk);
    wait_done(8'hFF, got);
    chk(got == 8'h01 && bell_q[16] == 1'b0, "R11 re-ring ok", 32'(got), 32'h01);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule